// File: doc/BRIEF.md
# Instruction Framing Sequencer for an 8-bit Bus Processor

This block watches a processor's bus one completed cycle at a time. Each cycle arrives as a kind (opcode fetch, memory read or write, I/O read or write, interrupt acknowledge) together with the byte seen on the data lines. The sequencer groups consecutive cycles into whole instructions. An instruction is made of optional prefix bytes, the opcode, an optional signed displacement, up to two immediate bytes, and then the operand transfers that the instruction performs on memory or I/O.

To know how many bytes follow an opcode, the sequencer asks an external descriptor table through a combinational lookup port. It presents the 16-bit prefix and the opcode, and in the same clock gets back a hit flag, a displacement flag, an immediate count, a read count, a signed write count and a repeat flag. When an instruction is complete, the block pulses a record holding the prefix, opcode, displacement, immediate, read operand, write operand and length in bus cycles. A malformed sequence produces a pulsed 2-bit error code instead. After either outcome the sequencer returns to idle. If a cycle ended the previous item without belonging to it, that same cycle is examined again as a possible new opcode fetch, so no fetch is lost.

Top module: `ifrm_seq`

## Requirements
- R1: Cycle kinds are encoded on `cyc_kind` as 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 opcode fetch, 5 interrupt acknowledge. While idle, any cycle that is not an opcode fetch produces no output and starts nothing.
- R2: A fetched 0xCB, 0xED, 0xDD or 0xFD while idle is a prefix. While in the prefix state, a fetched 0xDD, 0xED or 0xFD replaces the held prefix, and the lookup then receives `{8'h00, latest prefix}`.
- R3: After a 0xDD or 0xFD prefix, a fetched 0xCB selects the long form. The prefix becomes `{first prefix, 8'hCB}`. The next cycle must be a memory read and carries the displacement; otherwise error 1 is raised. The cycle after that must be a memory read and carries the opcode; otherwise error 2 is raised.
- R4: Any cycle other than an opcode fetch that follows a prefix raises error 0.
- R5: A prefix/opcode pair that the table misses raises error 3 when the next cycle arrives. That cycle is then examined again from idle.
- R6: A displacement is one byte taken from the cycle after the opcode. The immediate is one or two bytes in little-endian order. Both are accepted from a cycle of any kind.
- R7: Read operands are taken only from memory-read or I/O-read cycles, and a 16-bit read is little-endian. Write operands are taken only from memory-write or I/O-write cycles. With a positive write count the first byte is the low byte; with a negative count it is the high byte.
- R8: When the repeat flag is set and the last operand of an iteration has been taken, the sequencer waits for the first read operand again and overwrites the operands. The record is reported once, when a non-matching cycle arrives, and carries the operands of the last iteration.
- R9: A record is reported as soon as its last operand is taken. If a cycle arrives that the instruction cannot use, the record is reported with the operands captured so far, and that same cycle is examined again from idle. `instr_len` counts the bus cycles consumed, prefixes included.
- R10: `instr_valid` and `err_valid` are single-clock pulses. Each is registered one clock after the cycle that caused it, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | A completed bus cycle is presented this clock |
| cyc_kind | input | 3 | Kind of the bus cycle (encoding in R1) |
| cyc_data | input | 8 | Data byte of the bus cycle |
| lk_prefix | output | 16 | Prefix presented to the descriptor table |
| lk_opcode | output | 8 | Opcode presented to the descriptor table |
| lk_hit | input | 1 | Table holds the presented pair |
| lk_disp | input | 1 | One displacement byte follows the opcode |
| lk_imm | input | CNT_W | Immediate byte count (values above 2 read as 2) |
| lk_rd | input | CNT_W | Read operand byte count (values above 2 read as 2) |
| lk_wr | input | CNT_W+1 | Signed write byte count; negative means high byte first |
| lk_rep | input | 1 | Repeating block instruction |
| instr_valid | output | 1 | Pulse: framed instruction record valid |
| instr_prefix | output | 16 | Prefix of the record |
| instr_opcode | output | 8 | Opcode of the record |
| instr_disp | output | 8 | Signed displacement |
| instr_imm | output | 16 | Immediate value |
| instr_rop | output | 16 | Read operand |
| instr_wop | output | 16 | Write operand |
| instr_len | output | LEN_W | Length in bus cycles |
| err_valid | output | 1 | Pulse: framing error |
| err_code | output | 2 | 0 no fetch after prefix, 1 missing displacement, 2 missing opcode, 3 unknown pair |

## Verification
Closing one item and opening the next can both happen on the same bus cycle. The cycle that ends a record or an error is immediately examined again as a fetch. The bench provokes this in three ways: an opcode fetch arrives while an instruction is still waiting for operands, a fetch arrives in place of the long-form displacement, and a fetch follows an unknown pair. The scoreboard expects the earlier record or error first. It then expects the later instruction with a length that starts from that shared cycle, which shows that the fetch was neither dropped nor counted twice.

// File: rtl/ifrm_pkg.sv
package ifrm_pkg;
  // bus cycle kinds
  localparam logic [2:0] K_MRD   = 3'd0;
  localparam logic [2:0] K_MWR   = 3'd1;
  localparam logic [2:0] K_IRD   = 3'd2;
  localparam logic [2:0] K_IWR   = 3'd3;
  localparam logic [2:0] K_FETCH = 3'd4;
  localparam logic [2:0] K_INTA  = 3'd5;

  // prefix byte values
  localparam logic [7:0] B_CB = 8'hCB;
  localparam logic [7:0] B_ED = 8'hED;
  localparam logic [7:0] B_DD = 8'hDD;
  localparam logic [7:0] B_FD = 8'hFD;

  // error codes
  localparam logic [1:0] E_NOFETCH = 2'd0;
  localparam logic [1:0] E_NODISP  = 2'd1;
  localparam logic [1:0] E_NOOPC   = 2'd2;
  localparam logic [1:0] E_UNKNOWN = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_PFX, S_CBDIS, S_CBOP, S_DIS, S_IMM1, S_IMM2, S_OPER, S_BAD
  } seq_st_t;
endpackage

// File: rtl/ifrm_classify.sv
module ifrm_classify
  import ifrm_pkg::*;
(
  input  logic [2:0] kind,
  input  logic [7:0] data,
  input  logic [7:0] held_pfx,
  output logic       is_fetch,
  output logic       is_memrd,
  output logic       is_rd,
  output logic       is_wr,
  output logic       pfx_any,
  output logic       pfx_chain,
  output logic       long_form
);
  logic held_idx;

  always_comb begin
    is_fetch  = (kind == K_FETCH);
    is_memrd  = (kind == K_MRD);
    is_rd     = (kind == K_MRD) || (kind == K_IRD);
    is_wr     = (kind == K_MWR) || (kind == K_IWR);
    pfx_chain = (data == B_DD) || (data == B_ED) || (data == B_FD);
    pfx_any   = pfx_chain || (data == B_CB);
    held_idx  = (held_pfx == B_DD) || (held_pfx == B_FD);
    long_form = held_idx && (data == B_CB);
  end
endmodule

// File: rtl/ifrm_emit.sv
module ifrm_emit #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             put_instr,
  input  logic             put_err,
  input  logic [1:0]       code,
  input  logic [15:0]      r_pfx,
  input  logic [7:0]       r_opc,
  input  logic [7:0]       r_disp,
  input  logic [15:0]      r_imm,
  input  logic [15:0]      r_rop,
  input  logic [15:0]      r_wop,
  input  logic [LEN_W-1:0] r_len,
  output logic             instr_valid,
  output logic [15:0]      instr_prefix,
  output logic [7:0]       instr_opcode,
  output logic [7:0]       instr_disp,
  output logic [15:0]      instr_imm,
  output logic [15:0]      instr_rop,
  output logic [15:0]      instr_wop,
  output logic [LEN_W-1:0] instr_len,
  output logic             err_valid,
  output logic [1:0]       err_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      instr_valid  <= 1'b0;
      err_valid    <= 1'b0;
      err_code     <= '0;
      instr_prefix <= '0;
      instr_opcode <= '0;
      instr_disp   <= '0;
      instr_imm    <= '0;
      instr_rop    <= '0;
      instr_wop    <= '0;
      instr_len    <= '0;
    end else begin
      instr_valid <= put_instr;
      err_valid   <= put_err;
      if (put_err) err_code <= code;
      if (put_instr) begin
        instr_prefix <= r_pfx;
        instr_opcode <= r_opc;
        instr_disp   <= r_disp;
        instr_imm    <= r_imm;
        instr_rop    <= r_rop;
        instr_wop    <= r_wop;
        instr_len    <= r_len;
      end
    end
  end
endmodule

// File: rtl/ifrm_seq.sv
module ifrm_seq
  import ifrm_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_valid,
  input  logic [2:0]       cyc_kind,
  input  logic [7:0]       cyc_data,
  output logic [15:0]      lk_prefix,
  output logic [7:0]       lk_opcode,
  input  logic             lk_hit,
  input  logic             lk_disp,
  input  logic [CNT_W-1:0] lk_imm,
  input  logic [CNT_W-1:0] lk_rd,
  input  logic [CNT_W:0]   lk_wr,
  input  logic             lk_rep,
  output logic             instr_valid,
  output logic [15:0]      instr_prefix,
  output logic [7:0]       instr_opcode,
  output logic [7:0]       instr_disp,
  output logic [15:0]      instr_imm,
  output logic [15:0]      instr_rop,
  output logic [15:0]      instr_wop,
  output logic [LEN_W-1:0] instr_len,
  output logic             err_valid,
  output logic [1:0]       err_code
);
  seq_st_t          st, n_st;
  logic [15:0]      pfx, n_pfx, r_pfx;
  logic [7:0]       opc, n_opc, r_opc, disp, n_disp, r_disp;
  logic [15:0]      imm, n_imm, r_imm, rop, n_rop, r_rop, wop, n_wop, r_wop;
  logic [LEN_W-1:0] len, n_len, r_len;
  logic [1:0]       imm_tot, n_imm_tot, rd_tot, n_rd_tot, rd_left, n_rd_left;
  logic [1:0]       wr_tot, n_wr_tot, wr_left, n_wr_left;
  logic             be, n_be, rep, n_rep;
  logic             put_i, put_e, reeval, take_op, fin;
  logic [1:0]       code;
  logic c_fetch, c_memrd, c_rd, c_wr, c_pfx_any, c_pfx_chain, c_long;

  // descriptor decode
  logic [1:0]     d_imm, d_rd, d_wr;
  logic [CNT_W:0] wr_mag;
  logic           d_be;

  ifrm_classify u_cls (
    .kind(cyc_kind), .data(cyc_data), .held_pfx(pfx[7:0]),
    .is_fetch(c_fetch), .is_memrd(c_memrd), .is_rd(c_rd), .is_wr(c_wr),
    .pfx_any(c_pfx_any), .pfx_chain(c_pfx_chain), .long_form(c_long)
  );

  function automatic logic [LEN_W-1:0] len_inc(input logic [LEN_W-1:0] v);
    return (v == {LEN_W{1'b1}}) ? v : v + 1'b1;
  endfunction

  always_comb begin
    d_be   = lk_wr[CNT_W];
    wr_mag = d_be ? (~lk_wr + 1'b1) : lk_wr;
    d_imm  = (lk_imm > CNT_W'(1)) ? 2'd2 : {1'b0, lk_imm[0]};
    d_rd   = (lk_rd > CNT_W'(1)) ? 2'd2 : {1'b0, lk_rd[0]};
    d_wr   = (wr_mag > (CNT_W+1)'(1)) ? 2'd2 : {1'b0, wr_mag[0]};
  end

  // lookup sees the held prefix only when the current byte is a prefixed opcode
  assign lk_opcode = cyc_data;
  assign lk_prefix = (((st == S_PFX) && c_fetch) || ((st == S_CBOP) && c_memrd)) ? pfx : 16'h0000;

  always_comb begin
    n_st = st; n_pfx = pfx; n_opc = opc; n_disp = disp; n_imm = imm;
    n_rop = rop; n_wop = wop; n_len = len; n_imm_tot = imm_tot;
    n_rd_tot = rd_tot; n_rd_left = rd_left; n_wr_tot = wr_tot; n_wr_left = wr_left;
    n_be = be; n_rep = rep;
    put_i = 1'b0; put_e = 1'b0; code = E_NOFETCH;
    reeval = 1'b0; take_op = 1'b0; fin = 1'b0;
    if (cyc_valid) begin
      case (st)
        S_IDLE: reeval = 1'b1;
        S_PFX: begin
          if (!c_fetch) begin
            put_e = 1'b1; code = E_NOFETCH; reeval = 1'b1;
          end else if (c_long) begin
            n_pfx = {pfx[7:0], cyc_data}; n_len = len_inc(len); n_st = S_CBDIS;
          end else if (c_pfx_chain) begin
            n_pfx = {8'h00, cyc_data}; n_len = len_inc(len);
          end else begin
            take_op = 1'b1;
          end
        end
        S_CBDIS: begin
          if (!c_memrd) begin
            put_e = 1'b1; code = E_NODISP; reeval = 1'b1;
          end else begin
            n_disp = cyc_data; n_len = len_inc(len); n_st = S_CBOP;
          end
        end
        S_CBOP: begin
          if (!c_memrd) begin
            put_e = 1'b1; code = E_NOOPC; reeval = 1'b1;
          end else begin
            take_op = 1'b1;
          end
        end
        S_DIS: begin
          n_disp = cyc_data; n_len = len_inc(len);
          n_st = (imm_tot != 2'd0) ? S_IMM1 : S_OPER;
        end
        S_IMM1: begin
          n_imm = {8'h00, cyc_data}; n_len = len_inc(len);
          n_st = (imm_tot == 2'd2) ? S_IMM2 : S_OPER;
        end
        S_IMM2: begin
          n_imm = {cyc_data, imm[7:0]}; n_len = len_inc(len); n_st = S_OPER;
        end
        S_OPER: begin
          if ((rd_left != 2'd0) && c_rd) begin
            n_rop = (rd_left == rd_tot) ? {8'h00, cyc_data} : {cyc_data, rop[7:0]};
            n_rd_left = rd_left - 2'd1; n_len = len_inc(len);
            fin = (n_rd_left == 2'd0) && (wr_left == 2'd0);
          end else if ((rd_left == 2'd0) && (wr_left != 2'd0) && c_wr) begin
            if (wr_left == wr_tot) n_wop = {8'h00, cyc_data};
            else n_wop = be ? {wop[7:0], cyc_data} : {cyc_data, wop[7:0]};
            n_wr_left = wr_left - 2'd1; n_len = len_inc(len);
            fin = (n_wr_left == 2'd0);
          end else begin
            put_i = 1'b1; reeval = 1'b1;
          end
          if (fin) begin
            if (rep && (rd_tot != 2'd0)) begin
              n_rd_left = rd_tot; n_wr_left = wr_tot;
            end else begin
              put_i = 1'b1; n_st = S_IDLE;
            end
          end
        end
        S_BAD: begin
          put_e = 1'b1; code = E_UNKNOWN; reeval = 1'b1;
        end
        default: n_st = S_IDLE;
      endcase
    end
    // record snapshot before any restart clears the fields
    r_pfx = n_pfx; r_opc = n_opc; r_disp = n_disp; r_imm = n_imm;
    r_rop = n_rop; r_wop = n_wop; r_len = n_len;
    if (reeval) begin
      n_st = S_IDLE; n_pfx = '0; n_opc = '0; n_disp = '0; n_imm = '0;
      n_rop = '0; n_wop = '0; n_len = '0;
      if (c_fetch) begin
        if (c_pfx_any) begin
          n_pfx = {8'h00, cyc_data}; n_len = len_inc('0); n_st = S_PFX;
        end else begin
          take_op = 1'b1;
        end
      end
    end
    if (take_op) begin
      n_opc = cyc_data; n_len = len_inc(n_len);
      if (!lk_hit) begin
        n_st = S_BAD;
      end else begin
        n_imm_tot = d_imm; n_rd_tot = d_rd; n_rd_left = d_rd;
        n_wr_tot = d_wr; n_wr_left = d_wr; n_be = d_be; n_rep = lk_rep;
        if (lk_disp) n_st = S_DIS;
        else if (d_imm != 2'd0) n_st = S_IMM1;
        else n_st = S_OPER;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; pfx <= '0; opc <= '0; disp <= '0; imm <= '0;
      rop <= '0; wop <= '0; len <= '0; imm_tot <= '0; rd_tot <= '0;
      rd_left <= '0; wr_tot <= '0; wr_left <= '0; be <= 1'b0; rep <= 1'b0;
    end else begin
      st <= n_st; pfx <= n_pfx; opc <= n_opc; disp <= n_disp; imm <= n_imm;
      rop <= n_rop; wop <= n_wop; len <= n_len; imm_tot <= n_imm_tot;
      rd_tot <= n_rd_tot; rd_left <= n_rd_left; wr_tot <= n_wr_tot;
      wr_left <= n_wr_left; be <= n_be; rep <= n_rep;
    end
  end

  ifrm_emit #(.LEN_W(LEN_W)) u_emit (
    .clk(clk), .rst(rst), .put_instr(put_i), .put_err(put_e), .code(code),
    .r_pfx(r_pfx), .r_opc(r_opc), .r_disp(r_disp), .r_imm(r_imm),
    .r_rop(r_rop), .r_wop(r_wop), .r_len(r_len),
    .instr_valid(instr_valid), .instr_prefix(instr_prefix),
    .instr_opcode(instr_opcode), .instr_disp(instr_disp), .instr_imm(instr_imm),
    .instr_rop(instr_rop), .instr_wop(instr_wop), .instr_len(instr_len),
    .err_valid(err_valid), .err_code(err_code)
  );
endmodule

// File: rtl/ifrm_seq_chk.sv
module ifrm_seq_chk
  import ifrm_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_valid,
  input logic [2:0]       cyc_kind,
  input logic [15:0]      lk_prefix,
  input logic             instr_valid,
  input logic [LEN_W-1:0] instr_len,
  input logic             err_valid,
  input logic [1:0]       err_code
);
  // R10: record and error never pulse together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(instr_valid && err_valid)) else $error("a_r10_exclusive");

  // R10: every output pulse is caused by a cycle one clock earlier
  a_r10_follows_cycle: assert property (@(posedge clk) disable iff (rst)
    (instr_valid || err_valid) |-> $past(cyc_valid)) else $error("a_r10_follows_cycle");

  // R4: error 0 only from a cycle that was not a fetch
  a_r4_nofetch: assert property (@(posedge clk) disable iff (rst)
    (err_valid && (err_code == E_NOFETCH)) |-> ($past(cyc_kind) != K_FETCH))
    else $error("a_r4_nofetch");

  // R3: long-form errors only from a cycle that was not a memory read
  a_r3_long_err: assert property (@(posedge clk) disable iff (rst)
    (err_valid && ((err_code == E_NODISP) || (err_code == E_NOOPC)))
      |-> ($past(cyc_kind) != K_MRD)) else $error("a_r3_long_err");

  // R2: a non-zero prefix is presented only with a fetch or a memory read
  a_r2_prefix_pres: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && (cyc_kind != K_FETCH) && (cyc_kind != K_MRD)) |-> (lk_prefix == 16'h0000))
    else $error("a_r2_prefix_pres");

  // R9: a reported instruction consumed at least one cycle
  a_r9_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    instr_valid |-> (instr_len != '0)) else $error("a_r9_len_nonzero");
endmodule

bind ifrm_seq ifrm_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
  .lk_prefix(lk_prefix), .instr_valid(instr_valid), .instr_len(instr_len),
  .err_valid(err_valid), .err_code(err_code)
);

// File: tb/ifrm_seq_bench.sv
module ifrm_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 5;
  localparam logic [2:0] MRD = 3'd0, MWR = 3'd1, IRD = 3'd2, IWR = 3'd3, FET = 3'd4, INTA = 3'd5;

  logic clk = 1'b0, rst = 1'b1;
  logic cyc_valid = 1'b0;
  logic [2:0] cyc_kind = 3'd0;
  logic [7:0] cyc_data = 8'h00;
  logic [15:0] lk_prefix;
  logic [7:0] lk_opcode;
  logic lk_hit, lk_disp, lk_rep;
  logic [1:0] lk_imm, lk_rd;
  logic [2:0] lk_wr;
  logic instr_valid, err_valid;
  logic [15:0] instr_prefix, instr_imm, instr_rop, instr_wop;
  logic [7:0] instr_opcode, instr_disp;
  logic [LEN_W-1:0] instr_len;
  logic [1:0] err_code;

  int checks = 0, fails = 0, outs = 0;
  bit done = 1'b0;

  typedef struct {
    string tag; bit is_err; logic [1:0] code;
    logic [15:0] pfx; logic [7:0] opc; logic [7:0] disp;
    logic [15:0] imm; logic [15:0] rop; logic [15:0] wop; logic [LEN_W-1:0] len;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ifrm_seq #(.LEN_W(LEN_W), .CNT_W(2)) u_ifrm_seq (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .cyc_data(cyc_data),
    .lk_prefix(lk_prefix), .lk_opcode(lk_opcode), .lk_hit(lk_hit), .lk_disp(lk_disp),
    .lk_imm(lk_imm), .lk_rd(lk_rd), .lk_wr(lk_wr), .lk_rep(lk_rep),
    .instr_valid(instr_valid), .instr_prefix(instr_prefix), .instr_opcode(instr_opcode),
    .instr_disp(instr_disp), .instr_imm(instr_imm), .instr_rop(instr_rop),
    .instr_wop(instr_wop), .instr_len(instr_len), .err_valid(err_valid), .err_code(err_code)
  );

  // stub descriptor table: {hit, disp, imm, rd, wr, rep}
  always_comb begin
    {lk_hit, lk_disp, lk_imm, lk_rd, lk_wr, lk_rep} = '0;
    case ({lk_prefix, lk_opcode})
      24'h000000: lk_hit = 1'b1;
      24'h00003E: begin lk_hit = 1'b1; lk_imm = 2'd1; end
      24'h000021: begin lk_hit = 1'b1; lk_imm = 2'd2; end
      24'h00007E: begin lk_hit = 1'b1; lk_rd = 2'd1; end
      24'h00002A: begin lk_hit = 1'b1; lk_imm = 2'd2; lk_rd = 2'd2; end
      24'h000022: begin lk_hit = 1'b1; lk_imm = 2'd2; lk_wr = 3'd2; end
      24'h0000E3: begin lk_hit = 1'b1; lk_rd = 2'd2; lk_wr = 3'b110; end
      24'h0000D3: begin lk_hit = 1'b1; lk_imm = 2'd1; lk_wr = 3'd1; end
      24'h000018: begin lk_hit = 1'b1; lk_disp = 1'b1; end
      24'h00DD7E: begin lk_hit = 1'b1; lk_disp = 1'b1; lk_rd = 2'd1; end
      24'hDDCB06: begin lk_hit = 1'b1; lk_rd = 2'd1; lk_wr = 3'd1; end
      24'h00EDB0: begin lk_hit = 1'b1; lk_rd = 2'd1; lk_wr = 3'd1; lk_rep = 1'b1; end
      default: ;
    endcase
  end

  task automatic cyc(input logic [2:0] k, input logic [7:0] d);
    @(negedge clk); cyc_valid = 1'b1; cyc_kind = k; cyc_data = d;
  endtask

  task automatic gap();
    @(negedge clk); cyc_valid = 1'b0;
  endtask

  task automatic exp_i(input string tag, input logic [15:0] p, input logic [7:0] o,
                       input logic [7:0] ds, input logic [15:0] im, input logic [15:0] r,
                       input logic [15:0] w, input logic [LEN_W-1:0] l);
    exp_t e;
    e.tag = tag; e.is_err = 1'b0; e.code = 2'd0; e.pfx = p; e.opc = o; e.disp = ds;
    e.imm = im; e.rop = r; e.wop = w; e.len = l;
    q.push_back(e);
  endtask

  task automatic exp_e(input string tag, input logic [1:0] c);
    exp_t e;
    e.tag = tag; e.is_err = 1'b1; e.code = c; e.pfx = '0; e.opc = '0; e.disp = '0;
    e.imm = '0; e.rop = '0; e.wop = '0; e.len = '0;
    q.push_back(e);
  endtask

  // monitor and scoreboard
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && (instr_valid || err_valid)) begin
        outs++;
        checks++;
        if (instr_valid && err_valid) begin
          fails++; $display("FAIL R10 both pulses high: actual 1/1 expected one");
        end else if (q.size() == 0) begin
          fails++; $display("FAIL R9 unexpected output: actual instr=%0b err=%0b expected none",
                            instr_valid, err_valid);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.is_err) begin
            if (!err_valid || err_code != e.code) begin
              fails++; $display("FAIL %s error: actual err=%0b code=%0d expected code=%0d",
                                e.tag, err_valid, err_code, e.code);
            end
          end else if (!instr_valid || instr_prefix != e.pfx || instr_opcode != e.opc ||
                       instr_disp != e.disp || instr_imm != e.imm || instr_rop != e.rop ||
                       instr_wop != e.wop || instr_len != e.len) begin
            fails++;
            $display("FAIL %s record: actual v=%0b %h/%h d=%h i=%h r=%h w=%h l=%0d expected %h/%h d=%h i=%h r=%h w=%h l=%0d",
                     e.tag, instr_valid, instr_prefix, instr_opcode, instr_disp, instr_imm,
                     instr_rop, instr_wop, instr_len, e.pfx, e.opc, e.disp, e.imm, e.rop,
                     e.wop, e.len);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // reset state
    checks++;
    if (instr_valid !== 1'b0 || err_valid !== 1'b0) begin
      fails++; $display("FAIL R10 reset: actual %0b/%0b expected 0/0", instr_valid, err_valid);
    end
    // R1: non-fetch cycles while idle are ignored
    cyc(MRD, 8'h55); cyc(IWR, 8'h12); cyc(INTA, 8'hFF); gap(); gap(); gap();
    checks++;
    if (outs != 0) begin
      fails++; $display("FAIL R1 idle ignore: actual %0d outputs expected 0", outs);
    end
    // R9 / R6: records closed by the next fetch, which starts the next instruction
    exp_i("R9", 16'h0000, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000, 5'd1);
    cyc(FET, 8'h00);
    exp_i("R6", 16'h0000, 8'h3E, 8'h00, 16'h0042, 16'h0000, 16'h0000, 5'd2);
    cyc(FET, 8'h3E); cyc(MRD, 8'h42);
    exp_i("R6", 16'h0000, 8'h21, 8'h00, 16'h1234, 16'h0000, 16'h0000, 5'd3);
    cyc(FET, 8'h21); cyc(MRD, 8'h34); cyc(MRD, 8'h12);
    // R7: a write cycle is not taken as a read operand
    exp_i("R7", 16'h0000, 8'h7E, 8'h00, 16'h0000, 16'h0000, 16'h0000, 5'd1);
    cyc(FET, 8'h7E); cyc(MWR, 8'h99);
    exp_i("R7", 16'h0000, 8'h7E, 8'h00, 16'h0000, 16'h005A, 16'h0000, 5'd2);
    cyc(FET, 8'h7E); cyc(IRD, 8'h5A);
    // R7: 16-bit read little-endian after immediate
    exp_i("R7", 16'h0000, 8'h2A, 8'h00, 16'h8000, 16'hABCD, 16'h0000, 5'd5);
    cyc(FET, 8'h2A); cyc(MRD, 8'h00); cyc(MRD, 8'h80); cyc(MRD, 8'hCD); cyc(MRD, 8'hAB);
    // R7: negative write count, first byte high
    exp_i("R7", 16'h0000, 8'hE3, 8'h00, 16'h0000, 16'h2211, 16'h3344, 5'd5);
    cyc(FET, 8'hE3); cyc(MRD, 8'h11); cyc(MRD, 8'h22); cyc(MWR, 8'h33); cyc(MWR, 8'h44);
    // R7: positive write count, first byte low
    exp_i("R7", 16'h0000, 8'h22, 8'h00, 16'h9000, 16'h0000, 16'h6655, 5'd5);
    cyc(FET, 8'h22); cyc(MRD, 8'h00); cyc(MRD, 8'h90); cyc(MWR, 8'h55); cyc(MWR, 8'h66);
    // R7: read cycle not taken as write operand, then I/O write taken
    exp_i("R7", 16'h0000, 8'hD3, 8'h00, 16'h007F, 16'h0000, 16'h0000, 5'd2);
    cyc(FET, 8'hD3); cyc(MRD, 8'h7F); cyc(IRD, 8'h00);
    exp_i("R7", 16'h0000, 8'hD3, 8'h00, 16'h007F, 16'h0000, 16'h0044, 5'd3);
    cyc(FET, 8'hD3); cyc(MRD, 8'h7F); cyc(IWR, 8'h44);
    // R2: chained prefixes, latest wins; displacement after opcode
    exp_i("R2", 16'h00DD, 8'h7E, 8'hF0, 16'h0000, 16'h0077, 16'h0000, 5'd5);
    cyc(FET, 8'hFD); cyc(FET, 8'hDD); cyc(FET, 8'h7E); cyc(MRD, 8'hF0); cyc(MRD, 8'h77);
    // R3: long form, displacement before opcode
    exp_i("R3", 16'hDDCB, 8'h06, 8'h05, 16'h0000, 16'h0080, 16'h0001, 5'd6);
    cyc(FET, 8'hDD); cyc(FET, 8'hCB); cyc(MRD, 8'h05); cyc(MRD, 8'h06);
    cyc(MRD, 8'h80); cyc(MWR, 8'h01);
    // R4: prefix not followed by fetch
    exp_e("R4", 2'd0);
    cyc(FET, 8'hED); cyc(MRD, 8'h00);
    // R3: missing displacement; the fetch restarts as a new opcode
    exp_e("R3", 2'd1);
    exp_i("R9", 16'h0000, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000, 5'd1);
    cyc(FET, 8'hDD); cyc(FET, 8'hCB); cyc(FET, 8'h00);
    // R3: missing opcode
    exp_e("R3", 2'd2);
    cyc(FET, 8'hDD); cyc(FET, 8'hCB); cyc(MRD, 8'h03); cyc(IRD, 8'h00);
    // R5: unknown pair reported on next cycle, which is re-examined
    exp_e("R5", 2'd3);
    exp_i("R6", 16'h0000, 8'h18, 8'hFE, 16'h0000, 16'h0000, 16'h0000, 5'd2);
    cyc(FET, 8'hED); cyc(FET, 8'h00); cyc(FET, 8'h18); cyc(MRD, 8'hFE);
    exp_i("R9", 16'h0000, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000, 5'd1);
    cyc(FET, 8'h00);
    // R8: repeating instruction loops on its read operand
    exp_i("R8", 16'h00ED, 8'hB0, 8'h00, 16'h0000, 16'h0011, 16'h0021, 5'd6);
    cyc(FET, 8'hED); cyc(FET, 8'hB0); cyc(MRD, 8'h10); cyc(MWR, 8'h20);
    cyc(MRD, 8'h11); cyc(MWR, 8'h21);
    exp_i("R9", 16'h0000, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000, 5'd1);
    cyc(FET, 8'h00); cyc(MWR, 8'h00);
    gap(); repeat (5) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++; $display("FAIL R10 missing outputs: actual %0d pending expected 0", q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule